// File: doc/BRIEF.md
# NAND Block Erase Sequencer

This block is the host-side engine that erases one 16 KB block of a NAND-style flash device. The device sits on an 8-bit bus shared by commands, addresses and data. A requester gives a one-cycle start pulse together with a 10-bit block number. The sequencer then sends the erase setup command, two row-address cycles and the erase confirm command. It waits out the device's busy period on the ready/busy line, sends the status command and reads back one status byte. Each bus write is a two-clock cycle: write-enable is low in the first clock and high in the second. The command latch, address latch and data stay steady across the rising write-enable edge. The status read is a two-clock cycle with read-enable low in the first clock, and the byte is captured at the end of that clock.

The outcome is a one-cycle done pulse plus four sticky flags: pass, fail, write-protected and timeout. Exactly one of these flags is set after each run. A configurable poll limit keeps a device that never leaves busy from hanging the sequencer. A busy output tells the requester when the next start will be taken.

Top module: `nand_erase_seq`

## Requirements
- R1: After reset, busy_o, done_o, all four result flags, cle_o, ale_o and io_oe_o are 0, while we_n_o and re_n_o are 1.
- R2: An accepted start produces exactly four bus writes, in this order: command 60h with cle_o=1, two address bytes with ale_o=1, then command D0h with cle_o=1. cle_o and ale_o are never high together, and io_out_o is stable across each rising edge of we_n_o.
- R3: The first address byte is {block[2:0], 5'b00000}, with the five ignored in-block bits driven to zero. The second address byte is {1'b0, block[9:3]}.
- R4: After the D0h write, the sequencer waits WB_CYC clocks and then polls rb_n_i. Once rb_n_i is sampled high, it writes command 70h and performs one read with re_n_o low. done_o is high in the fifth clock after rb_n_i rises, measured from a release made mid-cycle.
- R5: The status byte is decoded as follows. If bit 7 is 0, only prot_o is set. Otherwise, if bit 0 is 1 or bit 6 is 0, only fail_o is set. Otherwise only pass_o is set.
- R6: If rb_n_i stays low for TMO_CYC poll clocks, the run ends with only tmo_o set and no 70h write. done_o then rises 1+WB_CYC+TMO_CYC clocks after the D0h write-enable rise.
- R7: busy_o goes high on the clock edge that accepts a start and falls one clock after done_o. A start or block number presented while busy_o is high has no effect on the bus writes or the result.
- R8: done_o lasts exactly one clock. The result flags hold their value until the next accepted start.
- R9: we_n_o and re_n_o are never low together. io_oe_o is high only during write cycles and is low whenever re_n_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; taken only when busy_o is low |
| block_i | input | BLK_W | Block number to erase |
| busy_o | output | 1 | Sequencer is running |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Erase succeeded |
| fail_o | output | 1 | Erase error or device not ready |
| prot_o | output | 1 | Device is write-protected |
| tmo_o | output | 1 | Ready/busy did not return before the limit |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| we_n_o | output | 1 | Write enable, active low |
| re_n_o | output | 1 | Read enable, active low |
| io_out_o | output | 8 | Bus data driven to the device |
| io_oe_o | output | 1 | Bus output enable |
| io_in_i | input | 8 | Bus data from the device |
| rb_n_i | input | 1 | Ready (1) / busy (0) from the device |

## Verification
Each result has a fixed distance from the stimulus that causes it. Bus activity begins on the edge that takes the start. done_o appears five clocks after a mid-cycle release of ready/busy. On a timeout, done_o appears 1+WB_CYC+TMO_CYC clocks after the confirm's write-enable rise. busy_o drops one clock after done_o. The bench drives every input on the falling clock edge. It counts falling edges from the release, or from the confirm, until done_o is seen, and compares the count with these figures. It reads the flags on that same falling edge and checks busy_o on the next one. Bus writes are logged on each rising edge of write-enable and compared with sequences derived from the block number.

// File: rtl/nand_erase_pkg.sv
package nand_erase_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_SETUP_LO, ST_SETUP_HI, ST_ADR1_LO, ST_ADR1_HI,
    ST_ADR2_LO, ST_ADR2_HI, ST_CONF_LO, ST_CONF_HI, ST_SETTLE,
    ST_POLL, ST_STAT_LO, ST_STAT_HI, ST_READ_LO, ST_READ_HI, ST_FIN
  } seq_state_e;

  localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
  localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
  localparam logic [7:0] OP_STATUS      = 8'h70;

  localparam int ST_BIT_ERR   = 0;
  localparam int ST_BIT_READY = 6;
  localparam int ST_BIT_NOWP  = 7;

  typedef struct packed {
    logic ok;
    logic err;
    logic wp;
    logic tmo;
  } seq_result_t;
endpackage

// File: rtl/erase_addr_pack.sv
module erase_addr_pack #(
  parameter int BLK_W     = 10,
  parameter int SKIP_BITS = 5,
  parameter int NCYC      = 2
) (
  input  logic [BLK_W-1:0]       blk_i,
  output logic [NCYC-1:0][7:0]   bytes_o
);
  localparam int ROW_W = BLK_W + SKIP_BITS;
  localparam int PAD_W = NCYC * 8 - ROW_W;

  logic [NCYC*8-1:0] row_pad;
  // the in-block bits below the block number are always zero;
  // PAD_W must be at least 1 (default row leaves the top bit unused)
  assign row_pad = {{PAD_W{1'b0}}, blk_i, {SKIP_BITS{1'b0}}};

  for (genvar g = 0; g < NCYC; g++) begin : g_cyc
    assign bytes_o[g] = row_pad[g*8 +: 8];
  end
endmodule

// File: rtl/erase_timer.sv
module erase_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)     cnt_d = '0;
    else if (en_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/erase_status_decode.sv
module erase_status_decode
  import nand_erase_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr_i,
  input  logic        cap_stat_i,
  input  logic        cap_tmo_i,
  input  logic [7:0]  stat_i,
  output seq_result_t res_o
);
  seq_result_t res_q, res_d, dec;

  always_comb begin
    dec = '0;
    if (!stat_i[ST_BIT_NOWP])                               dec.wp  = 1'b1;
    else if (stat_i[ST_BIT_ERR] || !stat_i[ST_BIT_READY])   dec.err = 1'b1;
    else                                                    dec.ok  = 1'b1;
  end

  always_comb begin
    res_d = res_q;
    if (clr_i)           res_d = '0;
    else if (cap_tmo_i)  res_d = '{ok: 1'b0, err: 1'b0, wp: 1'b0, tmo: 1'b1};
    else if (cap_stat_i) res_d = dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= res_d;
  end

  assign res_o = res_q;
endmodule

// File: rtl/erase_ctrl.sv
module erase_ctrl
  import nand_erase_pkg::*;
#(
  parameter int WB_CYC  = 3,
  parameter int TMO_CYC = 2048,
  parameter int CNT_W   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             rb_n_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [7:0]       adr0_i,
  input  logic [7:0]       adr1_i,
  output logic             accept_o,
  output logic             tmr_clr_o,
  output logic             tmr_en_o,
  output logic             cap_stat_o,
  output logic             cap_tmo_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             cle_o,
  output logic             ale_o,
  output logic             we_n_o,
  output logic             re_n_o,
  output logic             oe_o,
  output logic [7:0]       dq_o
);
  localparam logic [CNT_W-1:0] WB_LAST  = CNT_W'(WB_CYC - 1);
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TMO_CYC - 1);

  seq_state_e st_q, st_d;

  always_comb begin
    st_d       = st_q;
    accept_o   = 1'b0;
    tmr_clr_o  = 1'b0;
    tmr_en_o   = 1'b0;
    cap_tmo_o  = 1'b0;
    unique case (st_q)
      ST_IDLE:     if (start_i) begin st_d = ST_SETUP_LO; accept_o = 1'b1; end
      ST_SETUP_LO: st_d = ST_SETUP_HI;
      ST_SETUP_HI: st_d = ST_ADR1_LO;
      ST_ADR1_LO:  st_d = ST_ADR1_HI;
      ST_ADR1_HI:  st_d = ST_ADR2_LO;
      ST_ADR2_LO:  st_d = ST_ADR2_HI;
      ST_ADR2_HI:  st_d = ST_CONF_LO;
      ST_CONF_LO:  st_d = ST_CONF_HI;
      ST_CONF_HI:  begin st_d = ST_SETTLE; tmr_clr_o = 1'b1; end
      ST_SETTLE: begin
        if (cnt_i == WB_LAST) begin st_d = ST_POLL; tmr_clr_o = 1'b1; end
        else tmr_en_o = 1'b1;
      end
      ST_POLL: begin
        if (rb_n_i) st_d = ST_STAT_LO;
        else if (cnt_i == TMO_LAST) begin st_d = ST_FIN; cap_tmo_o = 1'b1; end
        else tmr_en_o = 1'b1;
      end
      ST_STAT_LO:  st_d = ST_STAT_HI;
      ST_STAT_HI:  st_d = ST_READ_LO;
      ST_READ_LO:  st_d = ST_READ_HI;
      ST_READ_HI:  st_d = ST_FIN;
      ST_FIN:      st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // bus strobes decoded from the state register
  always_comb begin
    cle_o  = 1'b0;
    ale_o  = 1'b0;
    we_n_o = 1'b1;
    re_n_o = 1'b1;
    oe_o   = 1'b0;
    dq_o   = 8'h00;
    unique case (st_q)
      ST_SETUP_LO, ST_SETUP_HI: begin
        cle_o = 1'b1; oe_o = 1'b1; dq_o = OP_ERASE_SETUP;
        we_n_o = (st_q != ST_SETUP_LO);
      end
      ST_ADR1_LO, ST_ADR1_HI: begin
        ale_o = 1'b1; oe_o = 1'b1; dq_o = adr0_i;
        we_n_o = (st_q != ST_ADR1_LO);
      end
      ST_ADR2_LO, ST_ADR2_HI: begin
        ale_o = 1'b1; oe_o = 1'b1; dq_o = adr1_i;
        we_n_o = (st_q != ST_ADR2_LO);
      end
      ST_CONF_LO, ST_CONF_HI: begin
        cle_o = 1'b1; oe_o = 1'b1; dq_o = OP_ERASE_GO;
        we_n_o = (st_q != ST_CONF_LO);
      end
      ST_STAT_LO, ST_STAT_HI: begin
        cle_o = 1'b1; oe_o = 1'b1; dq_o = OP_STATUS;
        we_n_o = (st_q != ST_STAT_LO);
      end
      ST_READ_LO: re_n_o = 1'b0;
      default: ;
    endcase
  end

  assign cap_stat_o = (st_q == ST_READ_LO);
  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = (st_q == ST_FIN);
endmodule

// File: rtl/nand_erase_seq.sv
module nand_erase_seq
  import nand_erase_pkg::*;
#(
  parameter int BLK_W     = 10,
  parameter int SKIP_BITS = 5,
  parameter int WB_CYC    = 3,
  parameter int TMO_CYC   = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [BLK_W-1:0] block_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             pass_o,
  output logic             fail_o,
  output logic             prot_o,
  output logic             tmo_o,
  output logic             cle_o,
  output logic             ale_o,
  output logic             we_n_o,
  output logic             re_n_o,
  output logic [7:0]       io_out_o,
  output logic             io_oe_o,
  input  logic [7:0]       io_in_i,
  input  logic             rb_n_i
);
  localparam int CNT_MAX = (TMO_CYC > WB_CYC) ? TMO_CYC : WB_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             accept, tmr_clr, tmr_en, cap_stat, cap_tmo;
  logic [CNT_W-1:0] cnt;
  logic [BLK_W-1:0] blk_q, blk_d;
  logic [1:0][7:0]  adr;
  seq_result_t      res;

  always_comb blk_d = accept ? block_i : blk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blk_q <= '0;
    else        blk_q <= blk_d;
  end

  erase_addr_pack #(.BLK_W(BLK_W), .SKIP_BITS(SKIP_BITS), .NCYC(2)) u_adr (
    .blk_i(blk_q), .bytes_o(adr)
  );

  erase_timer #(.W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr_i(tmr_clr), .en_i(tmr_en), .cnt_o(cnt)
  );

  erase_ctrl #(.WB_CYC(WB_CYC), .TMO_CYC(TMO_CYC), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rb_n_i(rb_n_i),
    .cnt_i(cnt), .adr0_i(adr[0]), .adr1_i(adr[1]),
    .accept_o(accept), .tmr_clr_o(tmr_clr), .tmr_en_o(tmr_en),
    .cap_stat_o(cap_stat), .cap_tmo_o(cap_tmo),
    .busy_o(busy_o), .done_o(done_o),
    .cle_o(cle_o), .ale_o(ale_o), .we_n_o(we_n_o), .re_n_o(re_n_o),
    .oe_o(io_oe_o), .dq_o(io_out_o)
  );

  erase_status_decode u_dec (
    .clk(clk), .rst_n(rst_n), .clr_i(accept), .cap_stat_i(cap_stat),
    .cap_tmo_i(cap_tmo), .stat_i(io_in_i), .res_o(res)
  );

  assign pass_o = res.ok;
  assign fail_o = res.err;
  assign prot_o = res.wp;
  assign tmo_o  = res.tmo;
endmodule

// File: rtl/nand_erase_chk.sv
module nand_erase_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       pass_o,
  input logic       fail_o,
  input logic       prot_o,
  input logic       tmo_o,
  input logic       cle_o,
  input logic       ale_o,
  input logic       we_n_o,
  input logic       re_n_o,
  input logic [7:0] io_out_o,
  input logic       io_oe_o
);
  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n_o && !re_n_o));
  assert_read_undriven_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n_o |-> !io_oe_o);
  assert_latch_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle_o && ale_o));
  assert_data_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n_o) |-> $stable(io_out_o) && $stable(cle_o) && $stable(ale_o));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_one_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $countones({pass_o, fail_o, prot_o, tmo_o}) == 1);
  assert_take_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);
  assert_release_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);
endmodule

bind nand_erase_seq nand_erase_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o), .prot_o(prot_o),
  .tmo_o(tmo_o), .cle_o(cle_o), .ale_o(ale_o), .we_n_o(we_n_o),
  .re_n_o(re_n_o), .io_out_o(io_out_o), .io_oe_o(io_oe_o)
);

// File: tb/sim_nand_erase_seq.sv
module sim_nand_erase_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WB   = 3;
  localparam int TMO  = 40;
  localparam int WDOG_CYC = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [9:0] blk = '0;
  logic       rb_n = 1'b1;
  logic [7:0] stat_byte = 8'h00;
  logic       busy, done, pass, fail, prot, tmo, cle, ale, we_n, re_n, oe;
  logic [7:0] dq, din;

  int n_cmp = 0;
  int n_bad = 0;

  logic [9:0] wlog [0:7];
  int         wcnt = 0;
  logic       conf_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign din = !re_n ? stat_byte : 8'h00;

  nand_erase_seq #(.BLK_W(10), .SKIP_BITS(5), .WB_CYC(WB), .TMO_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .block_i(blk),
    .busy_o(busy), .done_o(done), .pass_o(pass), .fail_o(fail),
    .prot_o(prot), .tmo_o(tmo), .cle_o(cle), .ale_o(ale), .we_n_o(we_n),
    .re_n_o(re_n), .io_out_o(dq), .io_oe_o(oe), .io_in_i(din), .rb_n_i(rb_n)
  );

  // device side: log every write on the rising write-enable edge
  always @(posedge we_n) begin
    if (rst_n) begin
      if (wcnt < 8) wlog[wcnt] = {cle, ale, dq};
      wcnt = wcnt + 1;
      if (cle && dq == 8'hD0) conf_seen = 1'b1;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // one erase; ecyc=0 means ready/busy never returns before the limit
  task automatic run_op(input logic [9:0] b, input logic [7:0] s, input int ecyc,
                        input logic poke);
    int n;
    logic [7:0] a1, a2;
    logic ep, ef, ew;
    logic seq_ok;
    wcnt = 0; conf_seen = 1'b0; stat_byte = s;
    @(negedge clk); start = 1'b1; blk = b;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R7 busy after start", busy, 1);
    if (poke) begin start = 1'b1; blk = ~b; @(negedge clk); start = 1'b0; end
    n = 0;
    while (!conf_seen && n < 50) begin @(negedge clk); n++; end
    rb_n = 1'b0;
    if (ecyc > 0) begin
      for (int i = 0; i < ecyc; i++) @(negedge clk);
      rb_n = 1'b1;
      n = 0;
      while (!done && n < 100) begin @(negedge clk); n++; end
      check(n == 5, "R4 done latency after ready", n, 5);
    end else begin
      n = 0;
      while (!done && n < 200) begin @(negedge clk); n++; end
      check(n == 1 + WB + TMO, "R6 timeout latency", n, 1 + WB + TMO);
    end
    a1 = {b[2:0], 5'b00000};
    a2 = {1'b0, b[9:3]};
    seq_ok = (wlog[0] == {2'b10, 8'h60}) && (wlog[1] == {2'b01, a1}) &&
             (wlog[2] == {2'b01, a2}) && (wlog[3] == {2'b10, 8'hD0});
    check(seq_ok, "R2 R3 erase write sequence", {wlog[1][7:0], wlog[2][7:0]}, {a1, a2});
    if (ecyc > 0) begin
      check(wcnt == 5 && wlog[4] == {2'b10, 8'h70}, "R4 status command", wcnt, 5);
      ew = !s[7];
      ef = s[7] && (s[0] || !s[6]);
      ep = s[7] && s[6] && !s[0];
      check({pass, fail, prot, tmo} == {ep, ef, ew, 1'b0}, "R5 status decode",
            {pass, fail, prot, tmo}, {ep, ef, ew, 1'b0});
    end else begin
      check(wcnt == 4, "R6 no status command", wcnt, 4);
      check({pass, fail, prot, tmo} == 4'b0001, "R6 timeout flag",
            {pass, fail, prot, tmo}, 1);
    end
    @(negedge clk);
    rb_n = 1'b1;
    check(!busy && !done, "R7 R8 idle after done", {busy, done}, 0);
  endtask

  initial begin
    for (int i = 0; i < WDOG_CYC; i++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WDOG_CYC, 0);
    finish_run();
  end

  initial begin
    logic [3:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check({busy, done, pass, fail, prot, tmo, cle, ale, oe, we_n, re_n} == 11'b00000000011,
          "R1 reset outputs", {busy, done, pass, fail, prot, tmo, cle, ale, oe, we_n, re_n}, 3);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 R3 R4: every block number, passing status
    for (int b = 0; b < 1024; b++) run_op(10'(b), 8'hC0, 5 + (b % 7), 1'b0);
    // R5: every status byte
    for (int s = 0; s < 256; s++) run_op(10'(s * 3), 8'(s), 6, 1'b0);
    // R6: timeout on several blocks
    run_op(10'h3FF, 8'hC0, 0, 1'b0);
    run_op(10'h155, 8'hC0, 0, 1'b0);
    // R7: start during busy ignored (address check inside uses first block)
    run_op(10'h2A5, 8'hC1, 9, 1'b1);
    run_op(10'h013, 8'h40, 12, 1'b1);
    // R8: flags held with no start
    held = {pass, fail, prot, tmo};
    for (int i = 0; i < 10; i++) @(negedge clk);
    check({pass, fail, prot, tmo} == held && wcnt == 4 + 1 && !busy,
          "R8 flags held while idle", {pass, fail, prot, tmo}, held);
    finish_run();
  end
endmodule